// File: doc/BRIEF.md
# Weekly Minute-Resolution Alarm

This block watches a running calendar time, given as packed BCD seconds, minutes and hours with a binary weekday code, and compares it against a programmed alarm. The alarm holds one minute value, one hour value and a seven-bit day mask. Each bit of the mask enables the alarm on one weekday, so a single setting can recur on any chosen set of days. Seconds are not programmable. The alarm fires at the start of the matching minute, when the seconds field reads zero.

A match raises a sticky pending flag exactly once per matching minute. Holding the time at the matching value does not set the flag again. A new event needs the match to drop and then return. The flag stays set until a one-cycle write-one-to-clear pulse arrives. The interrupt output is the pending flag gated by an enable bit. Driving the enable low masks the interrupt but keeps the flag. The time counter and the host register bus sit outside this block. Their values arrive here as plain inputs.

Top module: `wk_alarm_top`

## Requirements
- R1: After reset, `pendOut` and `irqOut` are both 0.
- R2: An event occurs when `curSec` is 8'h00, `curMin` equals `almMin`, `curHour` equals `almHour`, and bit `curWday` of `almDays` is 1. A match first seen at a rising clock edge makes `pendOut` read 1 after that edge.
- R3: While `curSec` is not 8'h00, no event occurs, whatever the other fields hold.
- R4: Bit n of `almDays` enables weekday code n, for n from 0 to 6, and any subset of bits may be set. A weekday whose bit is 0 never matches. The weekday code 7 never matches.
- R5: One match produces one event. If the match persists across edges after `pendOut` has been cleared, `pendOut` stays 0. A new event occurs only after the match has gone away and then returned.
- R6: `pendOut` stays 1 until a cycle with `pendClr` = 1. When no new event occurs in that cycle, `pendOut` reads 0 after that edge.
- R7: When a new event and `pendClr` = 1 fall in the same cycle, the event wins and `pendOut` stays 1.
- R8: `irqOut` equals `pendOut` AND `almEn`, combinationally. With `almEn` = 0, events still set `pendOut`, and raising `almEn` later exposes the pending event on `irqOut`.
- R9: Minute and hour are compared as whole BCD bytes. A difference in either field, by any amount, blocks the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curSec | input | 8 | Current seconds, packed BCD |
| curMin | input | 8 | Current minutes, packed BCD |
| curHour | input | 8 | Current hours, packed BCD |
| curWday | input | 3 | Current weekday code, 0 to 6 |
| almMin | input | 8 | Alarm minute, packed BCD |
| almHour | input | 8 | Alarm hour, packed BCD |
| almDays | input | 7 | Weekday enable mask, bit n for weekday n |
| almEn | input | 1 | Interrupt enable |
| pendClr | input | 1 | Write-one-to-clear pulse for the pending flag |
| pendOut | output | 1 | Sticky pending flag |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a new event and a clear pulse landing in the same cycle. It needs the flag already set, then the match made to drop, then the match returning on exactly the edge where `pendClr` is high. The bench builds this step by step. It raises the flag, moves the seconds off zero to drop the match, and then drives seconds back to zero together with the clear pulse. The one-shot rule is tested in a similar way. The bench clears the flag while the matching time is still held, then shows that only a drop followed by a return raises the flag again.

// File: rtl/wk_alarm_pkg.sv
package wk_alarm_pkg;
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } almStrobe_t;
endpackage

// File: rtl/wk_alarm_ctrl.sv
module wk_alarm_ctrl
  import wk_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       matchNow,
  input  logic       matchQ,
  input  logic       pendClr,
  output almStrobe_t strobe
);
  // an event is the first cycle of a match; a held match is ignored
  always_comb begin
    strobe.setPend = matchNow & ~matchQ;
    strobe.clrPend = pendClr;
  end

  AST_SET_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPend |-> matchNow);  // R2
endmodule

// File: rtl/wk_alarm_dp.sv
module wk_alarm_dp
  import wk_alarm_pkg::*;
#(
  parameter int TIME_W   = 8,
  parameter int NUM_DAYS = 7,
  parameter int WDAY_W   = 3
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [TIME_W-1:0]   curSec,
  input  logic [TIME_W-1:0]   curMin,
  input  logic [TIME_W-1:0]   curHour,
  input  logic [WDAY_W-1:0]   curWday,
  input  logic [TIME_W-1:0]   almMin,
  input  logic [TIME_W-1:0]   almHour,
  input  logic [NUM_DAYS-1:0] almDays,
  input  logic                almEn,
  input  almStrobe_t          strobe,
  output logic                matchNow,
  output logic                matchQ,
  output logic                pendOut,
  output logic                irqOut
);
  logic [NUM_DAYS-1:0] daySel;
  logic                dayHit;
  logic                timeHit;
  logic                pending;

  // one-hot decode of the weekday; codes past the last day select nothing
  genvar d;
  generate
    for (d = 0; d < NUM_DAYS; d++) begin : g_day
      assign daySel[d] = (curWday == WDAY_W'(d));
    end
  endgenerate

  always_comb begin
    dayHit   = |(daySel & almDays);
    timeHit  = (curSec == '0) && (curMin == almMin) && (curHour == almHour);
    matchNow = timeHit && dayHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchQ  <= 1'b0;
      pending <= 1'b0;
    end else begin
      matchQ <= matchNow;
      if (strobe.setPend)      pending <= 1'b1;
      else if (strobe.clrPend) pending <= 1'b0;
    end
  end

  assign pendOut = pending;
  assign irqOut  = pending & almEn;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && !matchQ) |=> pendOut);  // R2
  AST_NO_SEC_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (!pendOut && curSec != '0) |=> !pendOut);  // R3
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && matchQ && !pendOut) |=> !pendOut);  // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pendOut && !strobe.clrPend) |=> pendOut);  // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrPend && !(matchNow && !matchQ)) |=> !pendOut);  // R6
endmodule

// File: rtl/wk_alarm_top.sv
module wk_alarm_top
  import wk_alarm_pkg::*;
#(
  parameter int TIME_W   = 8,
  parameter int NUM_DAYS = 7,
  localparam int WDAY_W  = $clog2(NUM_DAYS + 1)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [TIME_W-1:0]   curSec,
  input  logic [TIME_W-1:0]   curMin,
  input  logic [TIME_W-1:0]   curHour,
  input  logic [WDAY_W-1:0]   curWday,
  input  logic [TIME_W-1:0]   almMin,
  input  logic [TIME_W-1:0]   almHour,
  input  logic [NUM_DAYS-1:0] almDays,
  input  logic                almEn,
  input  logic                pendClr,
  output logic                pendOut,
  output logic                irqOut
);
  almStrobe_t strobe;
  logic       matchNow;
  logic       matchQ;

  wk_alarm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .matchNow(matchNow), .matchQ(matchQ),
    .pendClr(pendClr), .strobe(strobe)
  );

  wk_alarm_dp #(.TIME_W(TIME_W), .NUM_DAYS(NUM_DAYS), .WDAY_W(WDAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curWday(curWday), .almMin(almMin),
    .almHour(almHour), .almDays(almDays), .almEn(almEn), .strobe(strobe),
    .matchNow(matchNow), .matchQ(matchQ), .pendOut(pendOut), .irqOut(irqOut)
  );

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (almEn && pendOut));  // R8
endmodule

// File: tb/tb_wk_alarm_top.sv
module tb_wk_alarm_top;
  logic       clk = 0;
  logic       rstN = 0;
  logic [7:0] curSec = 0, curMin = 0, curHour = 0;
  logic [2:0] curWday = 0;
  logic [7:0] almMin = 0, almHour = 0;
  logic [6:0] almDays = 0;
  logic       almEn = 0, pendClr = 0;
  logic       pendOut, irqOut;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  wk_alarm_top dut (
    .clk(clk), .rstN(rstN), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curWday(curWday), .almMin(almMin),
    .almHour(almHour), .almDays(almDays), .almEn(almEn),
    .pendClr(pendClr), .pendOut(pendOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [2:0] w);
    curSec = s; curMin = m; curHour = h; curWday = w;
  endtask

  task automatic clearPend();
    pendClr = 1; step(); pendClr = 0;
  endtask

  task automatic t_reset();
    step(); step();
    check("R1 pend at reset", pendOut, 1'b0);
    check("R1 irq at reset", irqOut, 1'b0);
    rstN = 1;
    step();
    check("R1 pend after release", pendOut, 1'b0);
  endtask

  task automatic t_basic();
    almMin = 8'h30; almHour = 8'h07; almDays = 7'b0000100; almEn = 1;
    setTime(8'h59, 8'h29, 8'h07, 3'd2); step();
    check("R3 before minute", pendOut, 1'b0);
    setTime(8'h00, 8'h30, 8'h07, 3'd2); step();
    check("R2 match sets pend", pendOut, 1'b1);
    check("R8 irq with enable", irqOut, 1'b1);
    clearPend();
    check("R6 clear", pendOut, 1'b0);
    step(); step();
    check("R5 held match no refire", pendOut, 1'b0);
    setTime(8'h01, 8'h30, 8'h07, 3'd2); step();
    check("R3 nonzero seconds", pendOut, 1'b0);
    setTime(8'h00, 8'h30, 8'h07, 3'd2); step();
    check("R5 refire after drop", pendOut, 1'b1);
    setTime(8'h01, 8'h30, 8'h07, 3'd2);
    clearPend();
  endtask

  task automatic t_days();
    almDays = 7'b1010101;
    for (int w = 0; w < 8; w++) begin
      setTime(8'h00, 8'h30, 8'h07, 3'(w)); step();
      check($sformatf("R4 weekday %0d", w), pendOut,
            (w < 7) ? almDays[w] : 1'b0);
      setTime(8'h01, 8'h30, 8'h07, 3'(w));
      clearPend();
    end
    almDays = 7'b0000000;
    setTime(8'h00, 8'h30, 8'h07, 3'd2); step();
    check("R4 empty mask", pendOut, 1'b0);
    setTime(8'h01, 8'h30, 8'h07, 3'd2); step();
    almDays = 7'b0000100;
  endtask

  task automatic t_mismatch();
    setTime(8'h00, 8'h30, 8'h08, 3'd2); step();
    check("R9 hour differs", pendOut, 1'b0);
    setTime(8'h01, 8'h30, 8'h07, 3'd2); step();
    setTime(8'h00, 8'h31, 8'h07, 3'd2); step();
    check("R9 minute differs", pendOut, 1'b0);
    setTime(8'h00, 8'h20, 8'h07, 3'd2); step();
    check("R9 minute tens differ", pendOut, 1'b0);
    setTime(8'h01, 8'h20, 8'h07, 3'd2); step();
  endtask

  task automatic t_enable();
    almEn = 0;
    setTime(8'h00, 8'h30, 8'h07, 3'd2); step();
    check("R8 pend while disabled", pendOut, 1'b1);
    check("R8 irq masked", irqOut, 1'b0);
    almEn = 1; #1;
    check("R8 irq on enable", irqOut, 1'b1);
    almEn = 0; #1;
    check("R8 irq off again", irqOut, 1'b0);
    almEn = 1;
    setTime(8'h01, 8'h30, 8'h07, 3'd2);
    clearPend();
  endtask

  task automatic t_collide();
    setTime(8'h00, 8'h30, 8'h07, 3'd2); step();
    setTime(8'h01, 8'h30, 8'h07, 3'd2);
    for (int i = 0; i < 5; i++) step();
    check("R6 sticky without clear", pendOut, 1'b1);
    setTime(8'h00, 8'h30, 8'h07, 3'd2);
    pendClr = 1; step(); pendClr = 0;
    check("R7 event beats clear", pendOut, 1'b1);
    setTime(8'h01, 8'h30, 8'h07, 3'd2);
    clearPend();
    check("R6 clear after collide", pendOut, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_days();
    t_mismatch();
    t_enable();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule